// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of each access inside a four-word burst. When a burst opens, the external address is captured. Its upper bits are then held for the whole burst. The two low bits give the starting offset. Each advance request moves the block to the next offset within the four-word group. A mode input chooses the order of the offsets. In interleaved order, the offset for access k is the starting offset XOR k. In linear order, it is the starting offset plus k, wrapping modulo four.

An advance request that arrives while the advance input is high is not taken. The block keeps its current address, so the burst pauses for as many cycles as the caller needs. A load always takes precedence over an advance on the same edge. The burst may start at any of the four offsets. After the fourth access, one more advance returns to the starting offset.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears its state, and after that edge `int_addr` reads 0.
- R2: When `load` is high at an edge, `int_addr` equals the `ext_addr` sampled at that edge from the following cycle on.
- R3: While `load` is low, the upper bits `int_addr[ADDR_W-1:2]` stay unchanged, whatever `ext_addr` does.
- R4: When `load` is low and `step_n` is high at an edge, `int_addr` keeps its value, provided `seq_mode` does not change.
- R5: With `seq_mode` = 1 (interleaved), the low two bits of the k-th access (k = 0..3) equal the start offset XOR k. For example, start 01 gives 01, 00, 11, 10.
- R6: With `seq_mode` = 0 (linear), the low two bits of the k-th access equal (start offset + k) mod 4. For example, start 11 gives 11, 00, 01, 10.
- R7: Once the fourth access has been produced, a further advance returns the low two bits to the start offset.
- R8: When `load` and an advance (`step_n` = 0) occur on the same edge, the load wins and the output becomes the new external address.
- R9: `seq_mode` selects the order combinationally. Changing it in the middle of a burst, with the position k unchanged, moves `int_addr` at once to the value of the other order for that k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Start a new burst from `ext_addr` |
| step_n | input | 1 | Active-low advance request; high pauses the burst |
| seq_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| ext_addr | input | ADDR_W | External start address |
| int_addr | output | ADDR_W | Address of the current access |

## Verification
Two functions can fall in the same cycle: loading a new start address and advancing the running burst. The bench raises `load` together with an active `step_n` while a burst is half-way through. It does this once in linear order and once in interleaved order. Each time it judges that the output after the edge is exactly the new external address, with no offset step applied. The bench then confirms that the next advance continues from that new start.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Offset field width; the burst length follows from it.
    localparam int OFS_W     = 2;
    localparam int BURST_LEN = 1 << OFS_W;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Position within the burst, together with the captured start offset.
    typedef struct packed {
        ofs_t start;
        ofs_t pos;
    } burst_pos_t;

    function automatic ofs_t map_offset(input ofs_t start, input ofs_t pos, input order_e ord);
        ofs_t r;
        if (ord == ORD_INTERLEAVE) r = start ^ pos;
        else                       r = ofs_t'(start + pos);
        return r;
    endfunction

endpackage

// File: rtl/burst_step_counter.sv
module burst_step_counter
    import burst_addr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step_n,
    output ofs_t pos
);

    ofs_t pos_q;

    always_ff @(posedge clk) begin
        if (rst)           pos_q <= '0;
        else if (load)     pos_q <= '0;
        else if (!step_n)  pos_q <= ofs_t'(pos_q + ofs_t'(1));
    end

    assign pos = pos_q;

    // R4: a paused burst keeps its position
    a_r4_hold_pos: assert property (@(posedge clk) disable iff (rst)
        (!load && step_n) |=> $stable(pos_q));

    // R7: advancing past the last access returns to position zero
    a_r7_wrap_pos: assert property (@(posedge clk) disable iff (rst)
        (!load && !step_n && pos_q == ofs_t'(BURST_LEN-1)) |=> (pos_q == '0));

    // R8: a load restarts the position even when an advance is requested
    a_r8_load_restart: assert property (@(posedge clk) disable iff (rst)
        (load && !step_n) |=> (pos_q == '0));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base
);

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst)       base_q <= '0;
        else if (load) base_q <= ext_addr;
    end

    assign base = base_q;

    // R2: a load captures the external address
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> (base_q == $past(ext_addr)));

    // R3: without a load the captured address does not move
    a_r3_base_kept: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(base_q));

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
    import burst_addr_pkg::*;
(
    input  burst_pos_t bp,
    input  order_e     ord,
    output ofs_t       ofs
);

    assign ofs = map_offset(bp.start, bp.pos, ord);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step_n,
    input  logic              seq_mode,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] int_addr
);

    localparam int HI_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] base;
    ofs_t              pos;
    ofs_t              ofs;
    burst_pos_t        bp;
    order_e            ord;

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .ext_addr (ext_addr),
        .base     (base)
    );

    burst_step_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step_n (step_n),
        .pos    (pos)
    );

    assign ord      = order_e'(seq_mode);
    assign bp.start = base[OFS_W-1:0];
    assign bp.pos   = pos;

    burst_offset_map u_map (
        .bp  (bp),
        .ord (ord),
        .ofs (ofs)
    );

    assign int_addr = {base[ADDR_W-1:OFS_W], ofs};

    // R1: reset leaves the output at zero
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (int_addr == '0));

    // R3: upper bits do not move between loads
    a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
        !load |=> (int_addr[ADDR_W-1:OFS_W] == $past(int_addr[ADDR_W-1:OFS_W])));

    // R6: linear order steps the offset by one
    a_r6_linear_inc: assert property (@(posedge clk) disable iff (rst)
        (!load && !step_n && !seq_mode) |=>
            (!seq_mode -> (int_addr[OFS_W-1:0] == ofs_t'($past(int_addr[OFS_W-1:0]) + ofs_t'(1)))));

    // R5: interleaved order always flips the lowest offset bit on an advance
    a_r5_interleave_flip: assert property (@(posedge clk) disable iff (rst)
        (!load && !step_n && seq_mode) |=>
            (seq_mode -> (int_addr[0] != $past(int_addr[0]))));

    initial begin
        a_hi_w_positive: assert (HI_W >= 1);
    end

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load = 1'b0;
    logic          step_n = 1'b1;
    logic          seq_mode = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] int_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step_n   (step_n),
        .seq_mode (seq_mode),
        .ext_addr (ext_addr),
        .int_addr (int_addr)
    );

    typedef struct packed {
        logic          ld;
        logic          stp_n;
        logic          md;
        logic [AW-1:0] ext;
        logic [AW-1:0] exp;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 1'b1, 18'h12341, 18'h12341, 4'd2},
        '{1'b0, 1'b0, 1'b1, 18'h00000, 18'h12340, 4'd5},
        '{1'b0, 1'b0, 1'b1, 18'h00000, 18'h12343, 4'd5},
        '{1'b0, 1'b0, 1'b1, 18'h00000, 18'h12342, 4'd5},
        '{1'b0, 1'b0, 1'b1, 18'h00000, 18'h12341, 4'd7},
        '{1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h12341, 4'd4},
        '{1'b1, 1'b1, 1'b0, 18'h2ABCE, 18'h2ABCE, 4'd2},
        '{1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h2ABCF, 4'd3},
        '{1'b0, 1'b0, 1'b0, 18'h00000, 18'h2ABCC, 4'd6},
        '{1'b0, 1'b0, 1'b0, 18'h00000, 18'h2ABCD, 4'd6},
        '{1'b0, 1'b0, 1'b0, 18'h00000, 18'h2ABCE, 4'd7},
        '{1'b1, 1'b0, 1'b0, 18'h00007, 18'h00007, 4'd8},
        '{1'b0, 1'b0, 1'b0, 18'h00000, 18'h00004, 4'd6},
        '{1'b0, 1'b0, 1'b0, 18'h00000, 18'h00005, 4'd6},
        '{1'b0, 1'b0, 1'b0, 18'h00000, 18'h00006, 4'd6},
        '{1'b1, 1'b0, 1'b1, 18'h3FFFE, 18'h3FFFE, 4'd8},
        '{1'b0, 1'b0, 1'b1, 18'h00000, 18'h3FFFF, 4'd5},
        '{1'b0, 1'b1, 1'b1, 18'h00000, 18'h3FFFF, 4'd4},
        '{1'b0, 1'b0, 1'b1, 18'h00000, 18'h3FFFC, 4'd5},
        '{1'b0, 1'b0, 1'b1, 18'h00000, 18'h3FFFD, 4'd5}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [AW-1:0] expv);
        n_checks++;
        if (int_addr !== expv) begin
            n_fails++;
            $display("FAIL %s: int_addr=%h expected=%h", req, int_addr, expv);
        end
    endtask

    task automatic drive_and_tick(input logic ld, input logic sn, input logic md,
                                  input logic [AW-1:0] ea);
        @(negedge clk);
        load = ld; step_n = sn; seq_mode = md; ext_addr = ea;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 5000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1", '0);
        @(negedge clk);
        rst = 1'b0;

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            drive_and_tick(VEC[i].ld, VEC[i].stp_n, VEC[i].md, VEC[i].ext);
            check(req_name(VEC[i].req), VEC[i].exp);
        end

        // R9: order is chosen combinationally at a fixed position
        drive_and_tick(1'b1, 1'b1, 1'b1, 18'h05551);
        drive_and_tick(1'b0, 1'b0, 1'b1, 18'h00000);
        check("R9", 18'h05550);
        @(negedge clk);
        step_n = 1'b1;
        seq_mode = 1'b0;
        #1;
        check("R9", 18'h05552);

        // R4: long pause with a moving external address, then resume
        for (int j = 0; j < 4; j++) begin
            drive_and_tick(1'b0, 1'b1, 1'b0, 18'(j * 18'h0F0F3));
            check("R4", 18'h05552);
        end
        drive_and_tick(1'b0, 1'b0, 1'b0, 18'h3FFFF);
        check("R6", 18'h05553);

        // R1: reset in the middle of a burst
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check("R1", '0);
        @(negedge clk);
        rst = 1'b0;
        step_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        done = 1'b1;
        $finish;
    end

endmodule